// File: doc/BRIEF.md
# Glitch-Free Master Clock Switchover

This block decides which of two clocks leaves the chip as the master clock: the clock recovered by the receiver's PLL, or an external system clock. Software sets a single enable bit to allow the switch. While the bit is set and the PLL reports that it has lost lock, the master clock output carries the external clock, so that logic fed from it keeps running when the incoming stream goes away. Once lock has returned and stayed for a debounce interval, the output goes back to the recovered clock. A strap input that marks hardware control mode keeps the feature off.

Each clock has its own gate enable. The enable is resynchronized in its own domain and changes only on that clock's falling edge. A domain may raise its enable only after it has seen the other domain's enable low. The output is therefore never driven by both clocks at once and never carries a shortened pulse. The lock indicator is asynchronous. It is synchronized and filtered over a programmable number of external clock cycles before it can start a handover. The reference clock for the serial bit and frame clock dividers comes straight from the recovered clock in every mode. Two status outputs report which gate is open.

Top module: `clksw_top`

## Requirements
- R1: While `rst_n` is low, `rec_active`, `ext_active` and `mclk_out` are all 0. Within 8 external clock cycles after release, `rec_active` is 1 and `mclk_out` follows `rec_clk`, whatever the lock input shows.
- R2: With `sw_enable` = 0, `mclk_out` follows `rec_clk` and `ext_active` stays 0, whether or not the PLL is locked.
- R3: With `sw_enable` = 1 and `hw_strap` = 0, if `pll_lock` stays 0 for longer than DEB_CYCLES + 12 external clock cycles, `mclk_out` follows `ext_clk` and `ext_active` = 1.
- R4: When `pll_lock` returns to 1 and stays there for the same interval, `mclk_out` follows `rec_clk` again and `rec_active` = 1.
- R5: `hw_strap` = 1 (hardware control mode) forces the recovered clock, including when it is raised while the external clock is selected.
- R6: A low pulse on `pll_lock` shorter than DEB_CYCLES external clock cycles causes no handover (`ext_active` never rises). A pulse longer than that causes exactly one handover.
- R7: `rec_active` and `ext_active` are never 1 together. No high or low phase of `mclk_out` is shorter than the shorter half period of the two input clocks.
- R8: `ext_active` = 1 exactly when `mclk_out` carries `ext_clk`, and `rec_active` = 1 exactly when it carries `rec_clk`.
- R9: `ser_ref_clk` follows `rec_clk` in every mode and never carries `ext_clk`.
- R10: Each gate enable changes only while its own clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rec_clk | input | 1 | Clock recovered by the PLL |
| ext_clk | input | 1 | External system clock. Also clocks the lock filter |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_enable | input | 1 | Software enable for automatic switchover |
| hw_strap | input | 1 | 1 = hardware control mode, switchover disabled |
| pll_lock | input | 1 | Asynchronous PLL lock indicator, 1 = locked |
| mclk_out | output | 1 | Master clock output, output only |
| ser_ref_clk | output | 1 | Source for the serial bit and frame clock dividers, always the recovered clock |
| ext_active | output | 1 | 1 while the external clock drives `mclk_out` |
| rec_active | output | 1 | 1 while the recovered clock drives `mclk_out` |

## Verification
A new selection request can arrive while the previous handover between the two gates is still in progress. The bench provokes this by dropping `sw_enable` in the same window in which the filtered loss of lock starts a move to the external clock. The bench judges the outcome in three ways. The output must end on the recovered clock. The glitch monitor must record no short phase on `mclk_out` at any time. The two status outputs must never be seen high together. Reset asserted while the external clock is selected provides a second overlap: reset and an open gate, with the debounce starting over after release.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

    typedef enum logic {
        SRC_REC = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic en;
    } leg_t;

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clksw_lock_filter.sv
`timescale 1ns/1ps
module clksw_lock_filter
    import clksw_pkg::*;
#(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    input  logic en_s,
    input  logic strap_s,
    input  logic ext_en,
    input  logic rec_en_s,
    output logic want_ext
);

    localparam int CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

    typedef struct packed {
        logic             lock_filt;
        logic [CNT_W-1:0] cnt;
        clk_src_e         want;
    } filt_t;

    filt_t    s_d, s_q;
    logic     mismatch;
    logic     settled;
    clk_src_e target;

    always_comb begin
        s_d      = s_q;
        mismatch = (lock_s != s_q.lock_filt);
        // the filtered lock flips only after a full run of disagreeing samples
        if (!mismatch) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == CNT_LAST) begin
            s_d.lock_filt = lock_s;
            s_d.cnt       = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        target  = (en_s && !strap_s && !s_q.lock_filt) ? SRC_EXT : SRC_REC;
        // the target is held until the last requested gate is actually open
        settled = (s_q.want == SRC_EXT) ? ext_en : rec_en_s;
        if (settled) s_d.want = target;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{lock_filt: 1'b1, cnt: '0, want: SRC_REC};
        else        s_q <= s_d;
    end

    assign want_ext = (s_q.want == SRC_EXT);

endmodule

// File: rtl/clksw_gate_leg.sv
`timescale 1ns/1ps
module clksw_gate_leg
    import clksw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic other_s,
    output logic en
);

    logic req_s;
    leg_t st_d, st_q;

    clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_s)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = req_s && !other_s;
    end

    // falling-edge update: the gate only moves while its clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;

endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top #(
    parameter int DEB_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic rec_clk,
    input  logic ext_clk,
    input  logic rst_n,
    input  logic sw_enable,
    input  logic hw_strap,
    input  logic pll_lock,
    output logic mclk_out,
    output logic ser_ref_clk,
    output logic ext_active,
    output logic rec_active
);

    localparam int CTL_W = 3;

    logic [CTL_W-1:0] ctl_s;
    logic             want_ext;
    logic             rec_en;
    logic             ext_en;
    logic             rec_en_x;
    logic             ext_en_r;

    clksw_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk   (ext_clk),
        .rst_n (rst_n),
        .d     ({pll_lock, sw_enable, hw_strap}),
        .q     (ctl_s)
    );

    clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rec2ext (
        .clk   (ext_clk),
        .rst_n (rst_n),
        .d     (rec_en),
        .q     (rec_en_x)
    );

    clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ext2rec (
        .clk   (rec_clk),
        .rst_n (rst_n),
        .d     (ext_en),
        .q     (ext_en_r)
    );

    clksw_lock_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
        .clk      (ext_clk),
        .rst_n    (rst_n),
        .lock_s   (ctl_s[2]),
        .en_s     (ctl_s[1]),
        .strap_s  (ctl_s[0]),
        .ext_en   (ext_en),
        .rec_en_s (rec_en_x),
        .want_ext (want_ext)
    );

    clksw_gate_leg #(.SYNC_STAGES(SYNC_STAGES)) u_ext_leg (
        .clk     (ext_clk),
        .rst_n   (rst_n),
        .req     (want_ext),
        .other_s (rec_en_x),
        .en      (ext_en)
    );

    clksw_gate_leg #(.SYNC_STAGES(SYNC_STAGES)) u_rec_leg (
        .clk     (rec_clk),
        .rst_n   (rst_n),
        .req     (!want_ext),
        .other_s (ext_en_r),
        .en      (rec_en)
    );

    assign mclk_out    = (rec_clk & rec_en) | (ext_clk & ext_en);
    assign ser_ref_clk = rec_clk;
    assign ext_active  = ext_en;
    assign rec_active  = rec_en;

endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk (
    input logic rec_clk,
    input logic ext_clk,
    input logic rst_n,
    input logic rec_en,
    input logic ext_en
);

    // R7
    mutex_ext_chk: assert property (@(posedge ext_clk) disable iff (!rst_n)
        !(rec_en && ext_en));

    // R7
    mutex_rec_chk: assert property (@(posedge rec_clk) disable iff (!rst_n)
        !(rec_en && ext_en));

    // R1
    reset_clear_chk: assert property (@(posedge ext_clk)
        !rst_n |-> (!rec_en && !ext_en));

    // R10
    always @(rec_en) begin
        if (rst_n) begin
            rec_gate_low_chk: assert (!rec_clk);
        end
    end

    // R10
    always @(ext_en) begin
        if (rst_n) begin
            ext_gate_low_chk: assert (!ext_clk);
        end
    end

endmodule

bind clksw_top clksw_chk u_chk (
    .rec_clk (rec_clk),
    .ext_clk (ext_clk),
    .rst_n   (rst_n),
    .rec_en  (rec_en),
    .ext_en  (ext_en)
);

// File: tb/sim_clksw_top.sv
`timescale 1ns/1ps
module sim_clksw_top;

    localparam int DEB = 16;

    // {sw_enable, hw_strap, pll_lock, expect_ext}
    localparam logic [3:0] VEC [0:9] = '{
        4'b0010, 4'b0000, 4'b1001, 4'b1010, 4'b1100,
        4'b1001, 4'b1100, 4'b1001, 4'b0000, 4'b1001
    };

    logic rec_clk = 1'b0;
    logic ext_clk = 1'b0;
    logic rst_n   = 1'b1;
    logic sw_enable = 1'b0;
    logic hw_strap  = 1'b0;
    logic pll_lock  = 1'b1;
    logic mclk_out, ser_ref_clk, ext_active, rec_active;

    int total = 0;
    int bad   = 0;
    int glitch_cnt = 0;
    int both_cnt   = 0;
    int ext_rise   = 0;
    bit done = 1'b0;
    realtime last_edge = 0.0;

    always #2.5 ext_clk = ~ext_clk;
    always #3.5 rec_clk = ~rec_clk;

    clksw_top #(.DEB_CYCLES(DEB)) u0 (
        .rec_clk     (rec_clk),
        .ext_clk     (ext_clk),
        .rst_n       (rst_n),
        .sw_enable   (sw_enable),
        .hw_strap    (hw_strap),
        .pll_lock    (pll_lock),
        .mclk_out    (mclk_out),
        .ser_ref_clk (ser_ref_clk),
        .ext_active  (ext_active),
        .rec_active  (rec_active)
    );

    always @(mclk_out) begin
        if (rst_n && last_edge > 0.0 && ($realtime - last_edge) < 2.4) glitch_cnt++;
        last_edge = $realtime;
    end

    always @(posedge ext_clk) if (ext_active && rec_active) both_cnt++;
    always @(posedge ext_active) ext_rise++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ext(input int n);
        repeat (n) @(posedge ext_clk);
        #1.1;
    endtask

    // sample mclk_out against one source away from every edge
    task automatic follows(input bit use_ext, input string req);
        int mism = 0;
        int smism = 0;
        @(posedge ext_clk);
        #0.25;
        for (int k = 0; k < 40; k++) begin
            if (mclk_out !== (use_ext ? ext_clk : rec_clk)) mism++;
            if (ser_ref_clk !== rec_clk) smism++;
            #1.3;
        end
        check(mism == 0, req, mism, 0);
        check(smism == 0, "R9 ser_ref_clk", smism, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        string tag;
        int mism;
        int rise0;
        #1 rst_n = 1'b0;
        wait_ext(5);
        // R1 reset state
        check(ext_active == 1'b0, "R1 ext_active in reset", ext_active, 0);
        check(rec_active == 1'b0, "R1 rec_active in reset", rec_active, 0);
        mism = 0;
        for (int k = 0; k < 20; k++) begin
            if (mclk_out !== 1'b0) mism++;
            #1.3;
        end
        check(mism == 0, "R1 mclk_out low in reset", mism, 0);
        rst_n = 1'b1;
        wait_ext(8);
        check(rec_active == 1'b1, "R1 recovered after release", rec_active, 1);
        follows(1'b0, "R1 follows rec after release");

        for (int i = 0; i < 10; i++) begin
            sw_enable = VEC[i][3];
            hw_strap  = VEC[i][2];
            pll_lock  = VEC[i][1];
            case (i)
                0, 1, 8: tag = "R2";
                3:       tag = "R4";
                4, 6:    tag = "R5";
                default: tag = "R3";
            endcase
            wait_ext(60);
            check(ext_active == VEC[i][0], {tag, " ext_active R8"}, ext_active, VEC[i][0]);
            check(rec_active == !VEC[i][0], {tag, " rec_active R8"}, rec_active, !VEC[i][0]);
            follows(VEC[i][0], {tag, " mclk_out source"});
        end

        // reset while external clock selected; debounce restarts
        rst_n = 1'b0;
        wait_ext(3);
        check(ext_active == 1'b0 && rec_active == 1'b0, "R1 reset while ext", ext_active + rec_active, 0);
        rst_n = 1'b1;
        wait_ext(8);
        check(rec_active == 1'b1, "R1 rec first after release", rec_active, 1);
        wait_ext(50);
        check(ext_active == 1'b1, "R3 ext after debounce", ext_active, 1);

        // R6 short lock drop ignored, long drop switches once
        pll_lock = 1'b1;
        wait_ext(60);
        check(rec_active == 1'b1, "R4 back to rec", rec_active, 1);
        rise0 = ext_rise;
        pll_lock = 1'b0;
        wait_ext(DEB - 6);
        pll_lock = 1'b1;
        wait_ext(50);
        check(ext_rise == rise0, "R6 short drop ignored", ext_rise - rise0, 0);
        follows(1'b0, "R6 still rec");
        pll_lock = 1'b0;
        wait_ext(DEB + 12);
        pll_lock = 1'b1;
        wait_ext(80);
        check(ext_rise == rise0 + 1, "R6 long drop one handover", ext_rise - rise0, 1);
        check(rec_active == 1'b1, "R4 rec after lock back", rec_active, 1);

        // overlap: enable dropped while the handover is starting
        pll_lock = 1'b0;
        wait_ext(DEB + 3);
        sw_enable = 1'b0;
        wait_ext(60);
        check(rec_active == 1'b1 && ext_active == 1'b0, "R2 rec after mid-handover disable", rec_active, 1);
        follows(1'b0, "R2 mclk_out after overlap");

        check(glitch_cnt == 0, "R7 no short phase", glitch_cnt, 0);
        check(both_cnt == 0, "R7 status exclusive", both_cnt, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule